// File: doc/BRIEF.md
# Peripheral Gate Controller

This block holds two levels of shutdown for a set of peripheral slots behind one byte-wide register bus. The hard level is a bank of disable registers, one bit per slot. A set bit removes the slot's clock enable and hides the slot's own registers from the bus, so the slot behaves as if it were not fitted. The soft level is bit 7 of each slot's control register. It stops the slot's operation but leaves its registers open, so software can reconfigure the slot and preload its buffers while it is idle.

The chip's power and clock logic uses three outputs per slot. The clock-enable and access-grant outputs follow the hard level only. The operation-enable output also needs the soft bit. Setting a slot's hard bit returns its control register to the reset value, so software must set the slot up again after it clears the bit. The disable registers can always be reached over the bus. Bit positions that have no peripheral behind them are tied off by a parameter mask.

Top module: `periph_gate_ctrl`

## Requirements
- R1: The disable registers sit at addresses 0x00 to 0x03. Bit n of register k is the hard-disable bit of slot 8k+n, and a 1 disables the slot. These registers can be read and written at any time.
- R2: With the default mask, slots 0, 16, 21 and 31 are unimplemented. Their disable bits always read 0 and ignore writes. All outputs of those slots stay 0, and their register addresses read 0x00.
- R3: After reset, every disable bit is 0 and every slot register is 0x00. Clock enable and access grant are 1 for each implemented slot, and every operation enable is 0.
- R4: While a slot's disable bit is 1, its clock-enable and access-grant outputs are 0. While the bit is 0, both are 1 for an implemented slot.
- R5: While a slot's disable bit is 1, writes to its registers are ignored and reads of them return 0x00.
- R6: Slot s has its control register at address 0x20+2s and its buffer register at 0x21+2s. The slot's operation enable is 1 exactly when its disable bit is 0 and bit 7 of its control register is 1. With bit 7 at 0, both registers still accept writes and return their values on reads.
- R7: While a slot's disable bit is 1, its control register is forced to 0x00. After the bit is cleared, the control register reads 0x00 and the buffer register keeps its earlier value.
- R8: A write takes effect at the first rising clock edge that sees the write strobe. The gating outputs change at that same edge.
- R9: Addresses that map to no register read 0x00, and writes to them change nothing. Read data is a combinational function of the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on / brown-out) |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| clk_en | output | NSLOT | Per-slot clock enable |
| acc_grant | output | NSLOT | Per-slot register access grant |
| op_en | output | NSLOT | Per-slot operation enable |

## Verification
Directed sequences cover the separate effects of the two levels on one slot. The soft bit alone leaves the registers writable. The hard bit hides the registers, clears the control register and keeps the buffer. Writes of all ones to the disable registers show that the unimplemented positions are masked, and reads of addresses outside the map must return zero. A constrained-random phase then mixes writes and reads over the disable registers, every slot register and unmapped space. This phase brings out the cases where a write meets a slot whose hard bit was set in the cycle before, and it checks every output bit after each edge against a bench model.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
   // index of the control register inside a slot window
   localparam int unsigned CTRL_IDX = 0;
   // soft-enable bit position in the control register
   localparam int unsigned SOFT_BIT = 7;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_DIS  = 2'd1,
      HIT_SLOT = 2'd2
   } hit_e;
endpackage

// File: rtl/pgc_dis_bank.sv
module pgc_dis_bank #(
   parameter int unsigned NREG   = 4,
   parameter int unsigned DATA_W = 8,
   parameter logic [NREG*DATA_W-1:0] IMPL_MASK = '1,
   localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SEL_W-1:0]       reg_sel,
   input  logic [DATA_W-1:0]      wdata,
   output logic [DATA_W-1:0]      rdata,
   output logic [NREG*DATA_W-1:0] hard_bits
);
   logic [DATA_W-1:0] bank_q [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      localparam logic [DATA_W-1:0] MASK_K = IMPL_MASK[k*DATA_W +: DATA_W];
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (reg_sel == SEL_W'(k)))
            q <= wdata & MASK_K;
      end
      assign bank_q[k] = q;
      assign hard_bits[k*DATA_W +: DATA_W] = q;

      // R1
      dis_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && reg_sel == SEL_W'(k)) |=> (q == ($past(wdata) & MASK_K)));
      // R2
      unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((q & ~MASK_K) == '0));
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NREG; k++)
         if (reg_sel == SEL_W'(k)) rdata = bank_q[k];
   end
endmodule

// File: rtl/pgc_slot.sv
module pgc_slot #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RPS      = 2,
   parameter logic [DATA_W-1:0] CTRL_RST = '0,
   localparam int unsigned IDX_W = $clog2(RPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hard_dis,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              clk_en,
   output logic              acc_grant,
   output logic              op_en
);
   import pgc_pkg::*;

   logic [DATA_W-1:0] regs_q [RPS];

   for (genvar i = 0; i < RPS; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      logic              hit;
      assign hit = wr_en && !hard_dis && (reg_idx == IDX_W'(i));
      if (i == CTRL_IDX) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= CTRL_RST;
            else if (hard_dis) q <= CTRL_RST;
            else if (hit)      q <= wdata;
         end
         // R7
         ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hard_dis |=> (q == CTRL_RST));
      end else begin : g_buf
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= wdata;
         end
         // R5
         buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hard_dis && wr_en) |=> $stable(q));
      end
      assign regs_q[i] = q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < RPS; i++)
         if (reg_idx == IDX_W'(i)) rdata = regs_q[i];
   end

   assign clk_en    = !hard_dis;
   assign acc_grant = !hard_dis;
   assign op_en     = !hard_dis && regs_q[CTRL_IDX][SOFT_BIT];

   // R4
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hard_dis |-> (!clk_en && !acc_grant && !op_en));
   // R6
   op_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_en |-> acc_grant);
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl #(
   parameter int unsigned DIS_REGS  = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned RPS       = 2,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned SLOT_BASE = 32'h20,
   parameter logic [DIS_REGS*DATA_W-1:0] IMPL_MASK = 32'h7FDE_FFFE,
   parameter logic [DATA_W-1:0] CTRL_RST = '0,
   localparam int unsigned NSLOT = DIS_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NSLOT-1:0]  clk_en,
   output logic [NSLOT-1:0]  acc_grant,
   output logic [NSLOT-1:0]  op_en
);
   import pgc_pkg::*;

   localparam int unsigned DSEL_W = $clog2(DIS_REGS);
   localparam int unsigned IDX_W  = $clog2(RPS);
   localparam int unsigned SLOT_W = $clog2(NSLOT);
   localparam int unsigned SPAN   = NSLOT * RPS;

   // elaboration-time parameter checks
   if (DATA_W < SOFT_BIT + 1) begin : g_bad_w
      $error("DATA_W must hold the soft-enable bit");
   end
   if (DIS_REGS < 2 || (1 << DSEL_W) != DIS_REGS) begin : g_bad_nreg
      $error("DIS_REGS must be a power of two >= 2");
   end
   if (RPS < 2 || (1 << IDX_W) != RPS) begin : g_bad_rps
      $error("RPS must be a power of two >= 2");
   end
   if (SLOT_BASE < DIS_REGS || SLOT_BASE + SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("slot window does not fit the address space");
   end

   // address decode
   hit_e              hit;
   logic [ADDR_W-1:0] off;
   logic [SLOT_W-1:0] slot_sel;
   logic [IDX_W-1:0]  reg_idx;

   assign off      = bus_addr - ADDR_W'(SLOT_BASE);
   assign slot_sel = SLOT_W'(off >> IDX_W);
   assign reg_idx  = IDX_W'(off);

   always_comb begin
      if (bus_addr < ADDR_W'(DIS_REGS))
         hit = HIT_DIS;
      else if (bus_addr >= ADDR_W'(SLOT_BASE) && off < ADDR_W'(SPAN))
         hit = HIT_SLOT;
      else
         hit = HIT_NONE;
   end

   // hard-disable bank
   logic [NSLOT-1:0]  hard_bits;
   logic [DATA_W-1:0] dis_rdata;

   pgc_dis_bank #(
      .NREG      (DIS_REGS),
      .DATA_W    (DATA_W),
      .IMPL_MASK (IMPL_MASK)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr && hit == HIT_DIS),
      .reg_sel   (DSEL_W'(bus_addr)),
      .wdata     (bus_wdata),
      .rdata     (dis_rdata),
      .hard_bits (hard_bits)
   );

   // per-slot register windows and gating
   logic [DATA_W-1:0] slot_rd [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      if (IMPL_MASK[s]) begin : g_impl
         pgc_slot #(
            .DATA_W   (DATA_W),
            .RPS      (RPS),
            .CTRL_RST (CTRL_RST)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .hard_dis  (hard_bits[s]),
            .wr_en     (bus_wr && hit == HIT_SLOT && slot_sel == SLOT_W'(s)),
            .reg_idx   (reg_idx),
            .wdata     (bus_wdata),
            .rdata     (slot_rd[s]),
            .clk_en    (clk_en[s]),
            .acc_grant (acc_grant[s]),
            .op_en     (op_en[s])
         );
      end else begin : g_absent
         assign slot_rd[s]   = '0;
         assign clk_en[s]    = 1'b0;
         assign acc_grant[s] = 1'b0;
         assign op_en[s]     = 1'b0;
      end
   end

   // read mux
   always_comb begin
      unique case (hit)
         HIT_DIS:  bus_rdata = dis_rdata;
         HIT_SLOT: bus_rdata = (IMPL_MASK[slot_sel] && !hard_bits[slot_sel])
                               ? slot_rd[slot_sel] : '0;
         default:  bus_rdata = '0;
      endcase
   end

   // R5
   hidden_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_SLOT && hard_bits[slot_sel]) |-> (bus_rdata == '0));
   // R9
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == HIT_NONE) |-> (bus_rdata == '0));
   // R2
   absent_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clk_en | acc_grant | op_en) & ~IMPL_MASK) == '0);
   // R8
   gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit == HIT_DIS && bus_wdata[1] && bus_addr == '0 && IMPL_MASK[1])
      |=> !clk_en[1]);
endmodule

// File: tb/periph_gate_ctrl_bench.sv
module periph_gate_ctrl_bench;
   localparam int NS = 32;
   localparam logic [31:0] MASK = 32'h7FDE_FFFE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [31:0] clk_en, acc_grant, op_en;

   always #2 clk = ~clk;

   periph_gate_ctrl u_periph_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en),
      .acc_grant(acc_grant), .op_en(op_en)
   );

   // bench model
   logic [31:0] m_dis;
   logic [7:0]  m_ctrl [NS];
   logic [7:0]  m_buf  [NS];
   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [7:0] a);
      int off;
      int s;
      if (a < 8'd4) return m_dis[a*8 +: 8];
      off = int'(a) - 32;
      if (a >= 8'h20 && off < 64) begin
         s = off / 2;
         if (MASK[s] && !m_dis[s]) return (off % 2 == 0) ? m_ctrl[s] : m_buf[s];
      end
      return 8'h00;
   endfunction

   function automatic logic [31:0] m_gate();
      return MASK & ~m_dis;
   endfunction

   function automatic logic [31:0] m_op();
      logic [31:0] r;
      for (int s = 0; s < NS; s++) r[s] = MASK[s] && !m_dis[s] && m_ctrl[s][7];
      return r;
   endfunction

   task automatic m_update(input logic w, input logic [7:0] a, input logic [7:0] d);
      logic [31:0] old;
      int off;
      int s;
      old = m_dis;
      for (int i = 0; i < NS; i++) if (old[i]) m_ctrl[i] = 8'h00;
      if (w) begin
         off = int'(a) - 32;
         if (a < 8'd4) m_dis[a*8 +: 8] = d & MASK[a*8 +: 8];
         else if (a >= 8'h20 && off < 64) begin
            s = off / 2;
            if (MASK[s] && !old[s]) begin
               if (off % 2 == 0) m_ctrl[s] = d;
               else m_buf[s] = d;
            end
         end
      end
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " clk_en"}, clk_en, m_gate());
      chk({tag, " acc_grant"}, acc_grant, m_gate());
      chk({tag, " op_en"}, op_en, m_op());
   endtask

   // one bus cycle: drive after negedge, check read before edge, check outputs after
   task automatic op(input logic w, input logic [7:0] a, input logic [7:0] d, input string tag);
      bus_wr = w; bus_addr = a; bus_wdata = d;
      #1;
      if (!w) chk({tag, " rdata"}, {24'd0, bus_rdata}, {24'd0, m_read(a)});
      @(posedge clk);
      m_update(w, a, d);
      @(negedge clk);
      bus_wr = 1'b0;
      check_outs(tag);
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      report();
   end

   initial begin
      int seed;
      logic [7:0] a;
      seed = $urandom(1234);
      m_dis = '0;
      for (int i = 0; i < NS; i++) begin m_ctrl[i] = '0; m_buf[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      check_outs("R3 reset");
      op(0, 8'h00, 8'h00, "R3 dis0 read");
      op(0, 8'h22, 8'h00, "R3 ctrl1 read");
      // R6 soft enable and access while idle
      op(1, 8'h23, 8'h5A, "R6 buf write idle");
      op(0, 8'h23, 8'h00, "R6 buf read idle");
      op(1, 8'h22, 8'h81, "R6 soft on");
      op(0, 8'h22, 8'h00, "R6 ctrl read");
      // R4 R8 hard disable slot 1 -> gating drops at the write edge
      op(1, 8'h00, 8'h02, "R4 R8 hard set");
      // R5 hidden: write ignored, read zero
      op(1, 8'h23, 8'hEE, "R5 hidden write");
      op(0, 8'h23, 8'h00, "R5 hidden read");
      op(0, 8'h22, 8'h00, "R5 hidden ctrl read");
      // R7 clear: ctrl reset, buffer kept
      op(1, 8'h00, 8'h00, "R7 hard clear");
      op(0, 8'h22, 8'h00, "R7 ctrl after clear");
      op(0, 8'h23, 8'h00, "R7 buf after clear");
      // R2 unimplemented positions
      for (int k = 0; k < 4; k++) op(1, 8'(k), 8'hFF, "R2 all ones");
      for (int k = 0; k < 4; k++) op(0, 8'(k), 8'h00, "R2 readback");
      for (int k = 0; k < 4; k++) op(1, 8'(k), 8'h00, "R2 clear");
      op(1, 8'h20, 8'h80, "R2 absent slot write");
      op(0, 8'h20, 8'h00, "R2 absent slot read");
      // R9 unmapped
      op(1, 8'h10, 8'hFF, "R9 gap write");
      op(0, 8'h10, 8'h00, "R9 gap read");
      op(0, 8'h60, 8'h00, "R9 above read");
      op(0, 8'hFF, 8'h00, "R9 top read");
      // constrained random (R1 R5 R6 R7 R8)
      for (int n = 0; n < 4000; n++) begin
         case ($urandom_range(0, 9))
            0, 1:    a = 8'($urandom_range(0, 3));
            9:       a = 8'($urandom_range(4, 255));
            default: a = 8'($urandom_range(32, 95));
         endcase
         op(1'($urandom_range(0, 1)), a, 8'($urandom()), "R1 R5 R6 R7 random");
      end
      report();
   end
endmodule